// File: doc/BRIEF.md
# Thyristor phase-angle trigger controller

This block is the digital core of a mains phase-control trigger stage. It watches the polarity of the line. Every change of that polarity is a zero crossing and begins a new half-cycle. At each crossing a timing ramp is reloaded to a full starting count. The ramp then counts down by one per clock. When the ramp equals the phase-delay command, a fire latch is set and a gate pulse of fixed length starts. So a larger command fires earlier in the half-cycle, and a command of zero fires latest.

The gate pulse goes to one of two outputs, chosen by the polarity of the half-cycle that is running: one output for the positive half-wave and one for the negative half-wave. The latch lets the block fire at most once per half-cycle. It is cleared only by the next zero crossing or by the inhibit input, and either of these overrides a set in the same cycle. A zero crossing cuts off any pulse still running. Holding inhibit high blanks the outputs at once and stops new firing.

Top module: `phase_trigger`

## Requirements
- R1: After reset, both gate outputs are low. No pulse is produced before the first change of `linePos`, even when the command already equals the ramp (ramp reset value 0, command 0).
- R2: A change of `linePos` passes a two-flop synchronizer and opens a sync window of SYNC_LEN cycles. During the window the ramp holds RAMP_START. After the window it decrements by one per cycle and stops at 0. For a command c with c ≤ RAMP_START, the active gate first reads high 3+SYNC_LEN+RAMP_START−c clock edges after the input change.
- R3: A command above RAMP_START behaves exactly like RAMP_START, which is the earliest firing point. A command of 0 gives the latest firing point, RAMP_START cycles after the window closes.
- R4: A match between ramp and command inside the sync window is ignored. A command of RAMP_START therefore fires on the first cycle after the window.
- R5: An uninterrupted gate pulse lasts exactly PULSE_LEN cycles.
- R6: A zero crossing ends any pulse in progress. The gate is low from the cycle in which the synchronized edge is seen, which is the second clock edge after the input change.
- R7: While `linePos` is 1 (after synchronization), pulses appear only on `gatePos`. While it is 0, they appear only on `gateNeg`. The two outputs are never high together.
- R8: At most one pulse is fired per half-cycle. A command that changes later in the half-cycle to equal the ramp again causes no second pulse.
- R9: While `inhibit` is high, both gates are low in that same cycle, the fire latch is cleared, and no new pulse can start. A pulse cut by `inhibit` does not resume. If `inhibit` covers the match cycle, that half-cycle does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| linePos | input | 1 | Line polarity, asynchronous; 1 = positive half-wave |
| phaseCmd | input | RAMP_W | Phase-delay command; larger fires earlier |
| inhibit | input | 1 | Pulse blocking, synchronous, active high |
| gatePos | output | 1 | Gate pulse for the positive half-wave |
| gateNeg | output | 1 | Gate pulse for the negative half-wave |

## Verification
Suppose the ramp or the window counter is off by one. The rising edge of the gate then moves by that many cycles in every half-cycle of a command sweep, so the first half-cycle already shows the error. A fire latch that is not cleared suppresses the pulse of the next half-cycle. A latch that clears too easily shows up as a second pulse once the command is moved onto the ramp again. A pulse counter that misses a clear shows up in the first one or two samples after a crossing, as a gate left high or as a pulse on the wrong output. Inhibit faults show up in the very sample in which inhibit is first high.

// File: rtl/phase_trigger_pkg.sv
package phase_trigger_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic reload;      // hold ramp at its start value
    logic clearAll;    // kill pulse timer
    logic startPulse;  // load pulse timer
  } strobe_t;
endpackage

// File: rtl/phase_trigger_ctrl.sv
module phase_trigger_ctrl
  import phase_trigger_pkg::*;
#(
  parameter int SYNC_LEN = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    linePosIn,
  input  logic    inhibit,
  input  logic    cmdHit,
  input  logic    pulseOn,
  output strobe_t strobes,
  output logic    zcEdge,
  output logic    gatePos,
  output logic    gateNeg
);
  localparam int SC_W = $clog2(SYNC_LEN + 1);

  logic polMeta, polSync, polPrev;
  logic [SC_W-1:0] syncCnt;
  logic syncWin, clearNow, memSet, fireMem, halfPos;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      polMeta <= 1'b0;
      polSync <= 1'b0;
      polPrev <= 1'b0;
    end else begin
      polMeta <= linePosIn;
      polSync <= polMeta;
      polPrev <= polSync;
    end
  end

  assign zcEdge   = polSync ^ polPrev;
  assign syncWin  = zcEdge | (syncCnt != '0);
  assign clearNow = zcEdge | inhibit;
  assign memSet   = cmdHit & ~syncWin & ~fireMem & ~inhibit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncCnt <= '0;
    end else if (zcEdge) begin
      syncCnt <= SC_W'(SYNC_LEN - 1);
    end else if (syncCnt != '0) begin
      syncCnt <= syncCnt - SC_W'(1);
    end
  end

  // fire memory: clear wins over set; spent until the first crossing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fireMem <= 1'b1;
    end else if (clearNow) begin
      fireMem <= 1'b0;
    end else if (memSet) begin
      fireMem <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfPos <= 1'b0;
    end else if (zcEdge) begin
      halfPos <= polSync;
    end
  end

  always_comb begin
    strobes.reload     = syncWin;
    strobes.clearAll   = clearNow;
    strobes.startPulse = memSet;
  end

  assign gatePos = pulseOn &  halfPos & ~clearNow;
  assign gateNeg = pulseOn & ~halfPos & ~clearNow;
endmodule

// File: rtl/phase_trigger_dp.sv
module phase_trigger_dp
  import phase_trigger_pkg::*;
#(
  parameter int RAMP_W     = 8,
  parameter int RAMP_START = 40,
  parameter int PULSE_LEN  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [RAMP_W-1:0] phaseCmd,
  output logic              cmdHit,
  output logic              pulseOn
);
  localparam int PW_W = $clog2(PULSE_LEN + 1);
  localparam logic [RAMP_W-1:0] START_V = RAMP_W'(RAMP_START);
  localparam logic [PW_W-1:0]   PULSE_V = PW_W'(PULSE_LEN);

  logic [RAMP_W-1:0] ramp, cmdEff;
  logic [PW_W-1:0]   pulseCnt;

  // front limit: clamp command to the ramp start
  assign cmdEff = (phaseCmd > START_V) ? START_V : phaseCmd;
  assign cmdHit = (ramp == cmdEff);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramp <= '0;
    end else if (strobes.reload) begin
      ramp <= START_V;
    end else if (ramp != '0) begin
      ramp <= ramp - RAMP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strobes.clearAll) begin
      pulseCnt <= '0;
    end else if (strobes.startPulse) begin
      pulseCnt <= PULSE_V;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - PW_W'(1);
    end
  end

  assign pulseOn = (pulseCnt != '0);
endmodule

// File: rtl/phase_trigger.sv
module phase_trigger
  import phase_trigger_pkg::*;
#(
  parameter int RAMP_W     = 8,
  parameter int RAMP_START = 40,
  parameter int SYNC_LEN   = 3,
  parameter int PULSE_LEN  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linePos,
  input  logic [RAMP_W-1:0] phaseCmd,
  input  logic              inhibit,
  output logic              gatePos,
  output logic              gateNeg
);
  strobe_t strobes;
  logic cmdHit, pulseOn, zcEdge;

  phase_trigger_ctrl #(.SYNC_LEN(SYNC_LEN)) ctrl (
    .clk(clk), .rstN(rstN), .linePosIn(linePos), .inhibit(inhibit),
    .cmdHit(cmdHit), .pulseOn(pulseOn), .strobes(strobes),
    .zcEdge(zcEdge), .gatePos(gatePos), .gateNeg(gateNeg)
  );

  phase_trigger_dp #(
    .RAMP_W(RAMP_W), .RAMP_START(RAMP_START), .PULSE_LEN(PULSE_LEN)
  ) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .phaseCmd(phaseCmd),
    .cmdHit(cmdHit), .pulseOn(pulseOn)
  );
endmodule

// File: rtl/phase_trigger_chk.sv
module phase_trigger_chk #(
  parameter int PULSE_LEN = 6
) (
  input logic clk,
  input logic rstN,
  input logic inhibit,
  input logic gatePos,
  input logic gateNeg,
  input logic zcEdge
);
  logic gateAny, gatePrev;
  logic [15:0] runLen;
  logic [1:0]  fireCnt;

  assign gateAny = gatePos | gateNeg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gatePrev <= 1'b0;
      runLen   <= '0;
      fireCnt  <= '0;
    end else begin
      gatePrev <= gateAny;
      runLen   <= gateAny ? ((runLen == 16'hFFFF) ? runLen : runLen + 16'd1) : 16'd0;
      if (zcEdge) fireCnt <= '0;
      else if (gateAny && !gatePrev && fireCnt != 2'd3) fireCnt <= fireCnt + 2'd1;
    end
  end

  p_gate_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(gatePos && gateNeg));

  p_pulse_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    gateAny |-> (runLen < 16'(PULSE_LEN)));

  p_single_fire_r8: assert property (@(posedge clk) disable iff (!rstN)
    fireCnt <= 2'd1);

  p_zc_cut_r6: assert property (@(posedge clk) disable iff (!rstN)
    zcEdge |=> !gateAny);

  p_inhibit_blank_r9: assert property (@(posedge clk) disable iff (!rstN)
    inhibit |=> !gateAny);
endmodule

bind phase_trigger phase_trigger_chk #(.PULSE_LEN(PULSE_LEN)) chk (
  .clk(clk), .rstN(rstN), .inhibit(inhibit),
  .gatePos(gatePos), .gateNeg(gateNeg), .zcEdge(zcEdge)
);

// File: tb/phase_trigger_test.sv
module phase_trigger_test;
  localparam int RW = 8;
  localparam int START = 40;
  localparam int SYNC = 3;
  localparam int PW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic linePos = 1'b0;
  logic [RW-1:0] phaseCmd = '0;
  logic inhibit = 1'b0;
  logic gatePos, gateNeg;

  int tests = 0;
  int fails = 0;
  int prevRise = 0, prevEnd = 0, prevHalf = 0;
  logic pol = 1'b0;

  always #2 clk = ~clk;

  phase_trigger #(.RAMP_W(RW), .RAMP_START(START), .SYNC_LEN(SYNC), .PULSE_LEN(PW)) uut (
    .clk(clk), .rstN(rstN), .linePos(linePos), .phaseCmd(phaseCmd),
    .inhibit(inhibit), .gatePos(gatePos), .gateNeg(gateNeg)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int clampCmd(input int c);
    return (c > START) ? START : c;
  endfunction

  // one half-cycle; sample n counted in clock edges after the polarity change
  task automatic runHalf(input string tag, input int c1, input int halfLen,
                         input int ia, input int ib, input int changeAt, input int c2);
    int m, m2, rise, fin, expFirst, expHi, expSpill;
    int first, hi, wrong, spill;
    logic act, opp;
    m1_blk: begin
      m = 2 + SYNC + START - clampCmd(c1);
      if (m >= changeAt - 1) begin
        m2 = 2 + SYNC + START - clampCmd(c2);
        m = (m2 >= changeAt - 1) ? m2 : -1;
      end
    end
    rise = (m < 0) ? 0 : m + 1;
    if (rise != 0 && ia <= rise && rise <= ib) rise = 0;
    fin = rise + PW - 1;
    if (rise != 0 && ia > rise && ia - 1 < fin) fin = ia - 1;
    expFirst = (rise != 0 && rise <= halfLen) ? rise : 0;
    expHi = 0;
    if (rise != 0 && rise <= halfLen) expHi = ((fin < halfLen) ? fin : halfLen) - rise + 1;
    expSpill = (prevRise != 0 && prevRise <= prevHalf + 1 && prevEnd >= prevHalf + 1) ? 1 : 0;

    pol = ~pol;
    linePos = pol;
    phaseCmd = RW'(c1);
    first = 0; hi = 0; wrong = 0; spill = 0;
    for (int n = 1; n <= halfLen; n++) begin
      if (n == changeAt) phaseCmd = RW'(c2);
      inhibit = (n >= ia && n <= ib);
      @(posedge clk);
      @(negedge clk);
      act = pol ? gatePos : gateNeg;
      opp = pol ? gateNeg : gatePos;
      if (n <= 2) begin
        spill += int'(opp);
        wrong += int'(act);
      end else begin
        if (act) begin
          if (first == 0) first = n;
          hi++;
        end
        wrong += int'(opp);
      end
    end
    inhibit = 1'b0;
    check(tag, "first gate sample", first, expFirst);
    check(tag, "gate high samples", hi, expHi);
    check("R7", "wrong-channel samples", wrong, 0);
    check("R6", "previous pulse after crossing", spill, expSpill);
    prevRise = rise; prevEnd = fin; prevHalf = halfLen;
  endtask

  initial begin
    #(4 * 190000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seen;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1", "gates in reset", int'(gatePos) + int'(gateNeg), 0);
    rstN = 1'b1;
    seen = 0;
    // R1: ramp 0 equals command 0, no crossing yet
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      seen += int'(gatePos) + int'(gateNeg);
    end
    check("R1", "pulses before first crossing", seen, 0);

    // R2/R5/R7 sweep over every command, R3/R4 at and above the start value
    for (int c = 0; c <= START + 3; c++)
      runHalf((c >= START) ? "R3" : "R2", c, 60, 1000, 1000, 1000, 0);
    runHalf("R4", START, 60, 1000, 1000, 1000, 0);
    runHalf("R5", 255, 60, 1000, 1000, 1000, 0);

    // R6: latest firing cut by the next crossing
    runHalf("R6", 0, 47, 1000, 1000, 1000, 0);
    runHalf("R6", 20, 60, 1000, 1000, 1000, 0);
    runHalf("R6", 0, 48, 1000, 1000, 1000, 0);
    runHalf("R6", 25, 60, 1000, 1000, 1000, 0);

    // R8: command moved onto the ramp again after firing
    runHalf("R8", 30, 60, 1000, 1000, 25, 15);
    runHalf("R8", 35, 60, 1000, 1000, 20, 5);

    // R9: inhibit during a pulse, across the match, and late
    runHalf("R9", 20, 60, 28, 40, 1000, 0);
    runHalf("R9", 10, 60, 20, 40, 1000, 0);
    runHalf("R9", 30, 60, 3, 10, 1000, 0);
    runHalf("R9", 20, 60, 1000, 1000, 1000, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule